// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block sits at the home memory node of a small shared-memory system and keeps coherence for a fixed set of memory blocks that several processors cache privately. The memory side records which caches hold each block, so there is no shared bus and no snooping. Every block has a directory entry: one presence bit per processor and one dirty flag. Read and write requests arrive tagged with the requesting processor and the block number. The controller consults the entry, talks only to the processors that the entry names, and sends a grant back to the requester when the block is safe to use.

A write to a shared block produces invalidations aimed only at the recorded sharers, never at the writer itself, and the grant waits for an acknowledgement from each of them. A request to a dirty block produces one fetch to the recorded owner. The fetch kind tells the owner either to keep a shared copy (read) or to give up its copy (write), and the grant waits for that owner's reply. Requests are served one at a time. A new request waits, with ready low, until the grant of the current one has been taken. Transport, data storage and the caches are outside the block and are reached through valid/ready message ports.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every directory entry is empty and clean, `reqReady` is 1, and `msgValid` and `grantValid` are 0.
- R2: A read to a clean block adds the requester as a sharer and raises `grantValid` two clock edges after the request handshake, with no message sent. The grant carries the requester's id, the block and `grantWrite`=0 for a read or 1 for a write.
- R3: A write to a clean block sends exactly one invalidation (`msgKind`=0) to each processor whose presence bit is set, except the writer, in ascending processor order.
- R4: A write is granted only after an acknowledgement on the response port from every invalidated processor. The writer then becomes the only holder and the block is dirty.
- R5: The requester is never the destination of an invalidation.
- R6: A request from a non-owner to a dirty block sends one fetch to the owner: `msgKind`=1 (keep a shared copy) for a read, `msgKind`=2 (surrender the copy) for a write. The grant waits for a response from that owner.
- R7: After a read of a dirty block is served, the block is clean and both the previous owner and the reader are sharers.
- R8: After a write to a dirty block is served, the writer is the only holder and is the owner of the dirty block.
- R9: A read or write by the current owner of a dirty block is granted two edges after the handshake, with no message sent.
- R10: From the request handshake until the grant handshake, `reqReady` stays 0.
- R11: While `msgValid` or `grantValid` is stalled by its ready, it stays high and its destination and kind stay unchanged.
- R12: During a fetch, a response from a processor other than the owner is taken and ignored. The grant still waits for the owner.
- R13: Directory entries of different blocks are independent. A request to one block leaves the others' presence and dirty state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller idle and accepting a request |
| reqWrite | input | 1 | 1 = write request, 0 = read request |
| reqId | input | $clog2(NPROC) | Requesting processor |
| reqBlk | input | $clog2(NBLK) | Requested block |
| msgValid | output | 1 | Outgoing invalidation or fetch valid |
| msgReady | input | 1 | Network accepts the outgoing message |
| msgKind | output | 2 | 0 invalidate, 1 fetch and keep shared, 2 fetch and surrender |
| msgDest | output | $clog2(NPROC) | Processor the message is sent to |
| msgBlk | output | $clog2(NBLK) | Block the message concerns |
| rspValid | input | 1 | Acknowledgement or write-back arriving from a processor |
| rspReady | output | 1 | Controller is waiting for responses |
| rspId | input | $clog2(NPROC) | Processor that sent the response |
| rspBlk | input | $clog2(NBLK) | Block the response concerns |
| grantValid | output | 1 | Request completed |
| grantReady | input | 1 | Requester takes the grant |
| grantWrite | output | 1 | Kind of the granted request |
| grantId | output | $clog2(NPROC) | Processor being granted |
| grantBlk | output | $clog2(NBLK) | Granted block |

## Verification
A wrong presence bit does not show at once. It shows on the next write or dirty-block request to that block: an invalidation goes to the wrong set of processors, or one is missing, or a fetch goes to a processor that is not the owner. The bench therefore chains requests to the same block and checks each message set, which shows the previous entry's state within one transaction. A wrong dirty flag shows as a fetch where none belongs, or a missing one. A wrong acknowledgement mask shows as a grant that comes before all responses arrive, or a transaction that never completes. The watchdog catches the second case.

// File: rtl/dirh_pkg.sv
package dirh_pkg;

  typedef enum logic [1:0] {
    MSG_INV         = 2'd0,
    MSG_FETCH_SHARE = 2'd1,
    MSG_FETCH_OWN   = 2'd2
  } msgKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic loadInv;
    logic sentOne;
    logic ackOne;
    logic addSharer;
    logic makeOwner;
  } dpCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic reqWr;
    logic entryDirty;
    logic ownerIsReq;
    logic othersNone;
    logic sendEmpty;
    logic ackEmpty;
    logic rspFromOwner;
  } dpSts_t;

endpackage

// File: rtl/dirh_datapath.sv
module dirh_datapath
  import dirh_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 4,
  localparam int IW = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic          reqWrite,
  input  logic [IW-1:0] reqId,
  input  logic [BW-1:0] reqBlk,
  input  logic [IW-1:0] rspId,
  input  logic [BW-1:0] rspBlk,
  output dpSts_t        sts,
  output logic          curWr,
  output logic [IW-1:0] curId,
  output logic [BW-1:0] curBlk,
  output logic [IW-1:0] invDest,
  output logic [IW-1:0] ownerId
);

  logic [NPROC-1:0] presQ [NBLK];
  logic [NBLK-1:0]  dirtyQ;
  logic             rWr;
  logic [IW-1:0]    rId;
  logic [BW-1:0]    rBlk;
  logic [NPROC-1:0] sendQ;
  logic [NPROC-1:0] ackQ;

  logic [NPROC-1:0] reqHot;
  logic [NPROC-1:0] entPres;
  logic             entDirty;
  logic [NPROC-1:0] others;

  assign reqHot   = NPROC'(1) << rId;
  assign entPres  = presQ[rBlk];
  assign entDirty = dirtyQ[rBlk];
  assign others   = entPres & ~reqHot;

  // lowest set presence bit names the owner of a dirty entry
  always_comb begin
    ownerId = '0;
    for (int i = NPROC - 1; i >= 0; i--) begin
      if (entPres[i]) ownerId = IW'(i);
    end
  end

  // next invalidation target: lowest pending bit, giving ascending order
  always_comb begin
    invDest = '0;
    for (int i = NPROC - 1; i >= 0; i--) begin
      if (sendQ[i]) invDest = IW'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rWr  <= 1'b0;
      rId  <= '0;
      rBlk <= '0;
    end else if (ctl.latchReq) begin
      rWr  <= reqWrite;
      rId  <= reqId;
      rBlk <= reqBlk;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sendQ <= '0;
    end else if (ctl.loadInv) begin
      sendQ <= others;
    end else if (ctl.sentOne) begin
      sendQ[invDest] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackQ <= '0;
    end else if (ctl.loadInv) begin
      ackQ <= others;
    end else if (ctl.ackOne && (rspBlk == rBlk)) begin
      ackQ[rspId] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NBLK; b++) presQ[b] <= '0;
      dirtyQ <= '0;
    end else begin
      for (int b = 0; b < NBLK; b++) begin
        if (rBlk == BW'(b)) begin
          if (ctl.makeOwner) begin
            presQ[b]  <= reqHot;
            dirtyQ[b] <= 1'b1;
          end else if (ctl.addSharer) begin
            presQ[b]  <= presQ[b] | reqHot;
            dirtyQ[b] <= 1'b0;
          end
        end
      end
    end
  end

  assign sts.reqWr        = rWr;
  assign sts.entryDirty   = entDirty;
  assign sts.ownerIsReq   = (ownerId == rId);
  assign sts.othersNone   = (others == '0);
  assign sts.sendEmpty    = (sendQ == '0);
  assign sts.ackEmpty     = (ackQ == '0);
  assign sts.rspFromOwner = (rspId == ownerId) && (rspBlk == rBlk);

  assign curWr  = rWr;
  assign curId  = rId;
  assign curBlk = rBlk;

endmodule

// File: rtl/dirh_control.sv
module dirh_control
  import dirh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       msgReady,
  input  logic       rspValid,
  input  logic       grantReady,
  input  dpSts_t     sts,
  output dpCtl_t     ctl,
  output logic       reqReady,
  output logic       msgValid,
  output logic [1:0] msgKind,
  output logic       msgUseOwner,
  output logic       rspReady,
  output logic       grantValid
);

  typedef enum logic [2:0] {
    S_IDLE, S_LOOKUP, S_FETCH_SEND, S_FETCH_WAIT, S_INV_SEND, S_INV_WAIT, S_REPLY
  } state_e;

  state_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    unique case (stateQ)
      S_IDLE: begin
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          stateD       = S_LOOKUP;
        end
      end
      S_LOOKUP: begin
        if (sts.entryDirty && !sts.ownerIsReq) begin
          stateD = S_FETCH_SEND;
        end else if (sts.entryDirty) begin
          stateD = S_REPLY;
        end else if (sts.reqWr) begin
          if (sts.othersNone) begin
            ctl.makeOwner = 1'b1;
            stateD        = S_REPLY;
          end else begin
            ctl.loadInv = 1'b1;
            stateD      = S_INV_SEND;
          end
        end else begin
          ctl.addSharer = 1'b1;
          stateD        = S_REPLY;
        end
      end
      S_FETCH_SEND: begin
        if (msgReady) stateD = S_FETCH_WAIT;
      end
      S_FETCH_WAIT: begin
        if (rspValid && sts.rspFromOwner) begin
          if (sts.reqWr) ctl.makeOwner = 1'b1;
          else           ctl.addSharer = 1'b1;
          stateD = S_REPLY;
        end
      end
      S_INV_SEND: begin
        ctl.ackOne = rspValid;
        if (sts.sendEmpty)  stateD      = S_INV_WAIT;
        else if (msgReady)  ctl.sentOne = 1'b1;
      end
      S_INV_WAIT: begin
        ctl.ackOne = rspValid;
        if (sts.ackEmpty) begin
          ctl.makeOwner = 1'b1;
          stateD        = S_REPLY;
        end
      end
      S_REPLY: begin
        if (grantReady) stateD = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  assign reqReady    = (stateQ == S_IDLE);
  assign msgValid    = (stateQ == S_FETCH_SEND) || ((stateQ == S_INV_SEND) && !sts.sendEmpty);
  assign msgUseOwner = (stateQ == S_FETCH_SEND);
  assign msgKind     = (stateQ != S_FETCH_SEND) ? MSG_INV
                     : (sts.reqWr ? MSG_FETCH_OWN : MSG_FETCH_SHARE);
  assign rspReady    = (stateQ == S_FETCH_WAIT) || (stateQ == S_INV_SEND) || (stateQ == S_INV_WAIT);
  assign grantValid  = (stateQ == S_REPLY);

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dirh_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 4,
  localparam int IW = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic          reqWrite,
  input  logic [IW-1:0] reqId,
  input  logic [BW-1:0] reqBlk,
  output logic          msgValid,
  input  logic          msgReady,
  output logic [1:0]    msgKind,
  output logic [IW-1:0] msgDest,
  output logic [BW-1:0] msgBlk,
  input  logic          rspValid,
  output logic          rspReady,
  input  logic [IW-1:0] rspId,
  input  logic [BW-1:0] rspBlk,
  output logic          grantValid,
  input  logic          grantReady,
  output logic          grantWrite,
  output logic [IW-1:0] grantId,
  output logic [BW-1:0] grantBlk
);

  dpCtl_t        ctl;
  dpSts_t        sts;
  logic          msgUseOwner;
  logic          curWr;
  logic [IW-1:0] curId;
  logic [BW-1:0] curBlk;
  logic [IW-1:0] invDest;
  logic [IW-1:0] ownerId;

  dirh_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .msgReady   (msgReady),
    .rspValid   (rspValid),
    .grantReady (grantReady),
    .sts        (sts),
    .ctl        (ctl),
    .reqReady   (reqReady),
    .msgValid   (msgValid),
    .msgKind    (msgKind),
    .msgUseOwner(msgUseOwner),
    .rspReady   (rspReady),
    .grantValid (grantValid)
  );

  dirh_datapath #(.NPROC(NPROC), .NBLK(NBLK)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqWrite(reqWrite),
    .reqId   (reqId),
    .reqBlk  (reqBlk),
    .rspId   (rspId),
    .rspBlk  (rspBlk),
    .sts     (sts),
    .curWr   (curWr),
    .curId   (curId),
    .curBlk  (curBlk),
    .invDest (invDest),
    .ownerId (ownerId)
  );

  assign msgDest    = msgUseOwner ? ownerId : invDest;
  assign msgBlk     = curBlk;
  assign grantWrite = curWr;
  assign grantId    = curId;
  assign grantBlk   = curBlk;

endmodule

// File: rtl/dirh_checker.sv
module dirh_checker #(
  parameter int NPROC = 4,
  parameter int NBLK  = 4,
  localparam int IW = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqReady,
  input logic          reqWrite,
  input logic [IW-1:0] reqId,
  input logic [BW-1:0] reqBlk,
  input logic          msgValid,
  input logic          msgReady,
  input logic [1:0]    msgKind,
  input logic [IW-1:0] msgDest,
  input logic          rspValid,
  input logic          rspReady,
  input logic [IW-1:0] rspId,
  input logic          grantValid,
  input logic          grantReady,
  input logic          grantWrite,
  input logic [IW-1:0] grantId,
  input logic [BW-1:0] grantBlk
);

  logic             busyQ;
  logic             wrQ;
  logic [IW-1:0]    idQ;
  logic [BW-1:0]    blkQ;
  logic [NPROC-1:0] pendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      wrQ   <= 1'b0;
      idQ   <= '0;
      blkQ  <= '0;
    end else begin
      if (reqValid && reqReady) begin
        busyQ <= 1'b1;
        wrQ   <= reqWrite;
        idQ   <= reqId;
        blkQ  <= reqBlk;
      end else if (grantValid && grantReady) begin
        busyQ <= 1'b0;
      end
    end
  end

  // processors that were sent a message and have not yet answered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
    end else begin
      if (rspValid && rspReady) pendQ[rspId] <= 1'b0;
      if (msgValid && msgReady) pendQ[msgDest] <= 1'b1;
    end
  end

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> !reqReady);

  // R5
  no_self_inv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgKind == 2'd0) |-> (msgDest != idQ));

  // R11
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgDest) && $stable(msgKind)));

  // R11
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !grantReady) |=> grantValid);

  // R2
  grant_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (busyQ && grantId == idQ && grantBlk == blkQ && grantWrite == wrQ));

  // R4
  ack_before_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ != '0) |-> !grantValid);

  // R6
  single_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(msgValid && grantValid));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> (!msgValid && !grantValid && !rspReady));

endmodule

bind dir_home_ctrl dirh_checker #(.NPROC(NPROC), .NBLK(NBLK)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqWrite  (reqWrite),
  .reqId     (reqId),
  .reqBlk    (reqBlk),
  .msgValid  (msgValid),
  .msgReady  (msgReady),
  .msgKind   (msgKind),
  .msgDest   (msgDest),
  .rspValid  (rspValid),
  .rspReady  (rspReady),
  .rspId     (rspId),
  .grantValid(grantValid),
  .grantReady(grantReady),
  .grantWrite(grantWrite),
  .grantId   (grantId),
  .grantBlk  (grantBlk)
);

// File: tb/tb_dir_home_ctrl.sv
`timescale 1ns/100ps
module tb_dir_home_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic       reqWrite = 1'b0;
  logic [1:0] reqId = '0;
  logic [1:0] reqBlk = '0;
  logic       msgValid;
  logic       msgReady = 1'b1;
  logic [1:0] msgKind;
  logic [1:0] msgDest;
  logic [1:0] msgBlk;
  logic       rspValid = 1'b0;
  logic       rspReady;
  logic [1:0] rspId = '0;
  logic [1:0] rspBlk = '0;
  logic       grantValid;
  logic       grantReady = 1'b1;
  logic       grantWrite;
  logic [1:0] grantId;
  logic [1:0] grantBlk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  dir_home_ctrl #(.NPROC(4), .NBLK(4)) dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite), .reqId(reqId), .reqBlk(reqBlk),
    .msgValid(msgValid), .msgReady(msgReady), .msgKind(msgKind), .msgDest(msgDest), .msgBlk(msgBlk),
    .rspValid(rspValid), .rspReady(rspReady), .rspId(rspId), .rspBlk(rspBlk),
    .grantValid(grantValid), .grantReady(grantReady), .grantWrite(grantWrite),
    .grantId(grantId), .grantBlk(grantBlk)
  );

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] lowest(input logic [3:0] m);
    logic [1:0] r = '0;
    for (int i = 3; i >= 0; i--) if (m[i]) r = 2'(i);
    return r;
  endfunction

  // one request from handshake to grant; responder answers every message
  task automatic doTxn(input logic wr, input logic [1:0] id, input logic [1:0] blk,
                       input logic [3:0] expMask, input logic [1:0] expKind,
                       input int spurId, input int mStallIn, input int gStallIn);
    logic [3:0] seen = '0;
    logic [3:0] pend = '0;
    logic [3:0] pendAtGrant = '0;
    int  lastDest = -1;
    int  lat = 0, gotLat = 0;
    int  mStall = mStallIn, gStall = gStallIn;
    bit  orderOk = 1, kindOk = 1, dupOk = 1, busyOk = 1, stableOk = 1, gHoldOk = 1;
    bit  done = 0, rspGoing = 0, spurLeft = (spurId >= 0), snap = 0, gHeld = 0;
    logic [1:0] snapD = '0, snapK = '0;
    logic [1:0] gId = '0, gBlk = '0;
    logic gWr = 1'b0;

    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqId = id; reqBlk = blk; rspBlk = blk;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    while (!done) begin
      lat++;
      if (reqReady) busyOk = 0;
      // response side
      if (rspGoing) begin
        rspValid = 1'b0;
        pend[rspId] = 1'b0;
        rspGoing = 0;
      end
      if (!rspValid && pend != '0) begin
        rspValid = 1'b1;
        if (spurLeft) begin rspId = 2'(spurId); spurLeft = 0; end
        else rspId = lowest(pend);
      end
      if (rspValid && rspReady) rspGoing = 1;
      // message side
      if (msgValid) begin
        if (snap && (msgDest != snapD || msgKind != snapK)) stableOk = 0;
        if (mStall > 0) begin
          snap = 1; snapD = msgDest; snapK = msgKind;
          mStall--; msgReady = 1'b0;
        end else begin
          snap = 0; msgReady = 1'b1;
          if (seen[msgDest]) dupOk = 0;
          if (int'(msgDest) <= lastDest) orderOk = 0;
          lastDest = int'(msgDest);
          seen[msgDest] = 1'b1;
          pend[msgDest] = 1'b1;
          if (msgKind != expKind) kindOk = 0;
        end
      end else begin
        msgReady = 1'b1;
      end
      // grant side
      if (grantValid) begin
        if (gStall > 0) begin
          gStall--; grantReady = 1'b0; gHeld = 1;
        end else begin
          grantReady = 1'b1; done = 1; gotLat = lat;
          pendAtGrant = pend; gId = grantId; gBlk = grantBlk; gWr = grantWrite;
        end
      end else begin
        if (gHeld) gHoldOk = 0;
        grantReady = 1'b1;
      end
      if (!done) @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    if (rspGoing) rspValid = 1'b0;

    check("R3 R6 R13 message destinations", seen == expMask, int'(seen), int'(expMask));
    if (expMask != '0) check("R3 R6 message kind", kindOk, int'(kindOk), 1);
    check("R3 ascending single messages", orderOk && dupOk, int'(orderOk && dupOk), 1);
    check("R4 R6 grant after all responses", pendAtGrant == '0, int'(pendAtGrant), 0);
    check("R10 reqReady low while busy", busyOk, int'(busyOk), 1);
    check("R2 grant id", gId == id, int'(gId), int'(id));
    check("R2 grant block", gBlk == blk, int'(gBlk), int'(blk));
    check("R2 grant kind", gWr == wr, int'(gWr), int'(wr));
    if (expMask == '0 && gStallIn == 0)
      check("R2 R9 grant latency", gotLat == 2, gotLat, 2);
    if (mStallIn > 0) check("R11 message held stable", stableOk, int'(stableOk), 1);
    if (gStallIn > 0) check("R11 grant held", gHoldOk, int'(gHoldOk), 1);
  endtask

  // {write, id, block, expected destination mask, expected kind}
  localparam int NV = 15;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 2'd0, 2'd0, 4'b0000, 2'd0},  // R1 R2 read of empty clean block
    {1'b0, 2'd1, 2'd0, 4'b0000, 2'd0},  // R2
    {1'b0, 2'd2, 2'd0, 4'b0000, 2'd0},  // R2
    {1'b1, 2'd1, 2'd0, 4'b0101, 2'd0},  // R3 R5 invalidate P0,P2 not P1
    {1'b0, 2'd3, 2'd0, 4'b0010, 2'd1},  // R4 R6 P1 is sole owner, fetch keep
    {1'b1, 2'd0, 2'd0, 4'b1010, 2'd0},  // R7 P1 and P3 both sharers
    {1'b1, 2'd2, 2'd0, 4'b0001, 2'd2},  // R6 fetch surrender from P0
    {1'b0, 2'd1, 2'd0, 4'b0100, 2'd1},  // R8 P2 now owner
    {1'b1, 2'd3, 2'd1, 4'b0000, 2'd0},  // R1 R13 untouched block is empty
    {1'b1, 2'd3, 2'd1, 4'b0000, 2'd0},  // R9 owner writes again
    {1'b0, 2'd3, 2'd1, 4'b0000, 2'd0},  // R9 owner reads
    {1'b0, 2'd0, 2'd2, 4'b0000, 2'd0},  // R2
    {1'b0, 2'd3, 2'd2, 4'b0000, 2'd0},  // R2
    {1'b1, 2'd0, 2'd2, 4'b1000, 2'd0},  // R5 sharer writer excluded
    {1'b1, 2'd1, 2'd0, 4'b0100, 2'd0}   // R7 R13 block 0 still shared P1,P2
  };

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reqReady in reset", reqReady == 1'b1, int'(reqReady), 1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reqReady after reset", reqReady == 1'b1, int'(reqReady), 1);
    check("R1 msgValid after reset", msgValid == 1'b0, int'(msgValid), 0);
    check("R1 grantValid after reset", grantValid == 1'b0, int'(grantValid), 0);

    for (int v = 0; v < NV; v++) begin
      doTxn(VEC[v][10], VEC[v][9:8], VEC[v][7:6], VEC[v][5:2], VEC[v][1:0], -1, 0, 0);
    end

    // R12: block 0 dirty, owner P1; spurious reply from P3 first
    doTxn(1'b0, 2'd0, 2'd0, 4'b0010, 2'd1, 3, 0, 0);
    // R7 follow-up: P0 and P1 now share block 0; P2 writes
    doTxn(1'b1, 2'd2, 2'd0, 4'b0011, 2'd0, -1, 0, 0);

    // R11: block 2 dirty, owner P0; stall message and grant
    doTxn(1'b1, 2'd2, 2'd2, 4'b0001, 2'd2, -1, 3, 3);
    // R11: invalidation stalls; block 1 owner P3 -> P3 read by P1 then write by P0
    doTxn(1'b0, 2'd1, 2'd1, 4'b1000, 2'd1, -1, 0, 0);
    doTxn(1'b1, 2'd0, 2'd1, 4'b1010, 2'd0, -1, 2, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule